// File: doc/BRIEF.md
# Elapsed-Time Clock with Interval Alarm

This block keeps wall-clock elapsed time from a 128 Hz tick pulse. A cascade of four counters holds the fraction of a second in 1/128 steps, seconds, minutes and hours. Each counter rolls over into the next one. Software can read and load every counter through a small register port. The tick itself is made elsewhere.

An interval alarm rides on the same cascade. Software writes an interval length and picks the unit that length is counted in: ticks, seconds, minutes or hours. The alarm counter advances once for each rollover of that unit. When the counter reaches the programmed length, a sticky interrupt flag is raised. The alarm then either reloads and runs again or stops, depending on a mode bit. The interrupt output is the flag itself, and a dedicated clear input lowers it.

Register map, 3-bit address, 8-bit data:

| Address | Contents |
|---|---|
| 0 | control: [0] clock run, [1] alarm enable, [2] single-shot, [4:3] unit (0 tick, 1 second, 2 minute, 3 hour), [7] interrupt flag (read only) |
| 1 | interval length |
| 2 | fraction of a second |
| 3 | seconds |
| 4 | minutes |
| 5 | hours |
| 6 | alarm count (read only) |

Read data is combinational from the address. A write takes effect at the clock edge on which `wr_en` is high.

Top module: `elapsed_interval_timer`

## Requirements
- R1: After reset, all time fields, the control register and the alarm count read 0, and `irq` is low.
- R2: While clock run (control bit 0) is 1, each `tick` pulse adds one to the fraction field. The fraction field wraps from 127 to 0 and adds one to seconds.
- R3: Seconds and minutes wrap from 59 to 0, and hours wraps from 23 to 0. Each wrap adds one to the next field, and the hours wrap is dropped.
- R4: While clock run is 0, `tick` pulses leave every time field unchanged.
- R5: A write to a time field or to the control register loads the written value, and counting continues from it.
- R6: The alarm count advances on each rollover of the unit chosen by control bits [4:3]: 0 every tick, 1 every second, 2 every minute, 3 every hour.
- R7: When the alarm count reaches the interval length, the flag is set. `irq` and control bit 7 both show the flag.
- R8: With single-shot 0, the alarm count returns to 0 when the alarm fires, and the alarm fires again after each further interval.
- R9: With single-shot 1, the alarm count holds its value after firing and never fires again until alarm enable is cleared and set again.
- R10: While alarm enable (control bit 1) is 0, the alarm count is held at 0.
- R11: An interval length of 0 never sets the flag.
- R12: The flag stays set until `irq_clr` is pulsed. If the alarm fires in the same cycle as `irq_clr`, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| tick | input | 1 | one-cycle 128 Hz time-base pulse |
| wr_en | input | 1 | register write strobe |
| addr | input | 3 | register address |
| wdata | input | 8 | register write data |
| rdata | output | 8 | register read data for `addr` |
| irq_clr | input | 1 | clears the interrupt flag |
| irq | output | 1 | interrupt request (the flag) |

## Verification
A wrong carry in the cascade shows up as a wrong field value on the next read after the tick that should have rolled the field over. Tests that start one tick before every boundary catch such a fault within one tick. A wrong unit select or a wrong compare moves the rise of `irq` earlier or later by whole units, so the bench checks that `irq` is still low one tick before the expected firing and high right after it. A wrong reload, hold or disable state is seen in the alarm-count readback and in whether `irq` rises again after a clear.

// File: rtl/tic_pkg.sv
package tic_pkg;
  localparam int NUM_FIELDS = 4;

  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_IVAL = 3'd1,
    A_FRAC = 3'd2,
    A_SEC  = 3'd3,
    A_MIN  = 3'd4,
    A_HOUR = 3'd5,
    A_ICNT = 3'd6,
    A_NONE = 3'd7
  } tic_addr_e;

  // Layout of control bits [4:0]
  typedef struct packed {
    logic [1:0] unit;
    logic       single;
    logic       alarm_en;
    logic       clk_run;
  } tic_ctrl_t;
endpackage

// File: rtl/tic_field.sv
module tic_field #(
  parameter int W     = 6,
  parameter int LIMIT = 60
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] value,
  output logic         carry
);
  localparam logic [W-1:0] TOP = W'(LIMIT - 1);

  logic at_top;
  assign at_top = (value >= TOP);
  assign carry  = inc && !wr && at_top;

  always_ff @(posedge clk) begin
    if (!rst_n)      value <= '0;
    else if (wr)     value <= wdata;
    else if (inc)    value <= at_top ? '0 : value + 1'b1;
  end

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr && value == TOP) |=> (value == '0));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !wr) |=> $stable(value));
endmodule

// File: rtl/tic_clock.sv
module tic_clock
  import tic_pkg::*;
#(
  parameter int DW         = 8,
  parameter int FRAC_LIMIT = 128,
  parameter int SEC_LIMIT  = 60,
  parameter int MIN_LIMIT  = 60,
  parameter int HOUR_LIMIT = 24
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          step,
  input  logic [NUM_FIELDS-1:0]         wr_sel,
  input  logic [DW-1:0]                 wdata,
  output logic [NUM_FIELDS-1:0][DW-1:0] vals,
  output logic [NUM_FIELDS:0]           carries
);
  localparam int LIMS [NUM_FIELDS] = '{FRAC_LIMIT, SEC_LIMIT, MIN_LIMIT, HOUR_LIMIT};

  assign carries[0] = step;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam int L = LIMS[i];
    localparam int W = $clog2(L);
    logic [W-1:0] v;
    tic_field #(.W(W), .LIMIT(L)) u_field (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (carries[i]),
      .wr    (wr_sel[i]),
      .wdata (wdata[W-1:0]),
      .value (v),
      .carry (carries[i+1])
    );
    assign vals[i] = DW'(v);
  end
endmodule

// File: rtl/tic_alarm.sv
module tic_alarm #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          single,
  input  logic          pulse,
  input  logic [CW-1:0] ival,
  input  logic          clr,
  output logic [CW-1:0] count,
  output logic          flag
);
  logic [CW-1:0] nxt;
  logic          done;
  logic          hit;
  logic          fire;

  assign nxt  = count + 1'b1;
  assign hit  = (ival != '0) && (nxt == ival);
  assign fire = en && pulse && !done && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      done  <= 1'b0;
    end else if (!en) begin
      count <= '0;
      done  <= 1'b0;
    end else if (pulse && !done) begin
      if (hit && !single) begin
        count <= '0;
      end else begin
        count <= nxt;
        if (hit) done <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    flag <= 1'b0;
    else if (fire) flag <= 1'b1;
    else if (clr)  flag <= 1'b0;
  end

  p_fire_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> flag);
  p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !single) |=> (count == '0));
  p_oneshot_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && done) |=> $stable(count));
  p_disable_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (count == '0));
  p_zero_never_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ival == '0 && !flag) |=> !flag);
  p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/elapsed_interval_timer.sv
module elapsed_interval_timer
  import tic_pkg::*;
#(
  parameter int DW         = 8,
  parameter int FRAC_LIMIT = 128,
  parameter int SEC_LIMIT  = 60,
  parameter int MIN_LIMIT  = 60,
  parameter int HOUR_LIMIT = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          irq_clr,
  output logic          irq
);
  localparam int CTRL_W = $bits(tic_ctrl_t);

  tic_ctrl_t                     ctrl;
  logic [DW-1:0]                 ival;
  logic [NUM_FIELDS-1:0]         field_wr;
  logic [NUM_FIELDS-1:0][DW-1:0] vals;
  logic [NUM_FIELDS:0]           carries;
  logic [DW-1:0]                 acount;
  logic                          flag;
  logic                          unit_pulse;

  // Control and interval registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      ival <= '0;
    end else if (wr_en) begin
      if (addr == A_CTRL) ctrl <= tic_ctrl_t'(wdata[CTRL_W-1:0]);
      if (addr == A_IVAL) ival <= wdata;
    end
  end

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_wsel
    assign field_wr[i] = wr_en && (addr == 3'(A_FRAC + i));
  end

  tic_clock #(
    .DW(DW), .FRAC_LIMIT(FRAC_LIMIT), .SEC_LIMIT(SEC_LIMIT),
    .MIN_LIMIT(MIN_LIMIT), .HOUR_LIMIT(HOUR_LIMIT)
  ) u_clock (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (tick && ctrl.clk_run),
    .wr_sel  (field_wr),
    .wdata   (wdata),
    .vals    (vals),
    .carries (carries)
  );

  assign unit_pulse = carries[ctrl.unit];

  tic_alarm #(.CW(DW)) u_alarm (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (ctrl.alarm_en),
    .single (ctrl.single),
    .pulse  (unit_pulse),
    .ival   (ival),
    .clr    (irq_clr),
    .count  (acount),
    .flag   (flag)
  );

  assign irq = flag;

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata             = DW'(ctrl);
        rdata[DW-1]       = flag;
      end
      A_IVAL: rdata = ival;
      A_FRAC: rdata = vals[0];
      A_SEC:  rdata = vals[1];
      A_MIN:  rdata = vals[2];
      A_HOUR: rdata = vals[3];
      A_ICNT: rdata = acount;
      default: rdata = '0;
    endcase
  end

  p_day_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (carries[NUM_FIELDS] && !field_wr[NUM_FIELDS-1]) |=> (vals[NUM_FIELDS-1] == '0));
endmodule

// File: tb/sim_elapsed_interval_timer.sv
module sim_elapsed_interval_timer;
  localparam logic [2:0] WR = 3'd0, RD = 3'd1, TK = 3'd2, IQ = 3'd3, CL = 3'd4;
  localparam logic [2:0] C = 3'd0, IV = 3'd1, FR = 3'd2, SC = 3'd3, MN = 3'd4, HR = 3'd5, IC = 3'd6;
  localparam int NV = 92;
  // {requirement, op, address, data-or-expected}
  localparam logic [17:0] VEC [NV] = '{
    {4'd1, RD, C, 8'h00}, {4'd1, RD, FR, 8'h00}, {4'd1, RD, HR, 8'h00}, {4'd1, IQ, C, 8'h00},   // R1
    {4'd4, TK, C, 8'd5},  {4'd4, RD, FR, 8'h00},                                              // R4
    {4'd2, WR, C, 8'h01}, {4'd2, TK, C, 8'd5},  {4'd2, RD, FR, 8'h05},                        // R2
    {4'd5, WR, FR, 8'h7E},{4'd5, RD, FR, 8'h7E},                                              // R5
    {4'd2, TK, C, 8'd2},  {4'd2, RD, FR, 8'h00}, {4'd2, RD, SC, 8'h01},                       // R2
    {4'd3, WR, SC, 8'h3B},{4'd3, WR, FR, 8'h7F}, {4'd3, TK, C, 8'd1},
    {4'd3, RD, SC, 8'h00},{4'd3, RD, MN, 8'h01},                                              // R3
    {4'd3, WR, MN, 8'h3B},{4'd3, WR, SC, 8'h3B}, {4'd3, WR, HR, 8'h17}, {4'd3, WR, FR, 8'h7F},
    {4'd3, TK, C, 8'd1},  {4'd3, RD, HR, 8'h00}, {4'd3, RD, MN, 8'h00},                       // R3
    {4'd5, WR, HR, 8'h05},{4'd5, RD, HR, 8'h05},                                              // R5
    {4'd6, WR, IV, 8'h03},{4'd6, WR, C, 8'h03},  {4'd6, TK, C, 8'd2},
    {4'd6, RD, IC, 8'h02},{4'd6, IQ, C, 8'h00},                                               // R6
    {4'd7, TK, C, 8'd1},  {4'd7, IQ, C, 8'h01},  {4'd8, RD, IC, 8'h00},                       // R7 R8
    {4'd12, TK, C, 8'd3}, {4'd12, IQ, C, 8'h01}, {4'd12, CL, C, 8'h00}, {4'd12, IQ, C, 8'h00},// R12
    {4'd8, TK, C, 8'd3},  {4'd8, IQ, C, 8'h01},  {4'd8, CL, C, 8'h00},                        // R8
    {4'd9, WR, C, 8'h07}, {4'd9, TK, C, 8'd3},   {4'd9, IQ, C, 8'h01}, {4'd9, CL, C, 8'h00},
    {4'd9, TK, C, 8'd3},  {4'd9, IQ, C, 8'h00},  {4'd9, RD, IC, 8'h03},                       // R9
    {4'd10, WR, C, 8'h05},{4'd10, RD, IC, 8'h00},{4'd10, TK, C, 8'd2}, {4'd10, RD, IC, 8'h00},// R10
    {4'd9, WR, C, 8'h07}, {4'd9, TK, C, 8'd3},   {4'd9, IQ, C, 8'h01}, {4'd9, CL, C, 8'h00},  // R9
    {4'd6, WR, C, 8'h01}, {4'd6, WR, IV, 8'h01}, {4'd6, WR, FR, 8'h00}, {4'd6, WR, C, 8'h0B},
    {4'd6, TK, C, 8'd127},{4'd6, IQ, C, 8'h00},  {4'd6, TK, C, 8'd1},  {4'd6, IQ, C, 8'h01},
    {4'd6, CL, C, 8'h00},                                                                     // R6 seconds
    {4'd11, WR, C, 8'h01},{4'd11, WR, IV, 8'h00},{4'd11, WR, C, 8'h03},{4'd11, TK, C, 8'd255},
    {4'd11, IQ, C, 8'h00},{4'd11, RD, IC, 8'hFF},                                             // R11
    {4'd6, WR, C, 8'h01}, {4'd6, WR, IV, 8'h01}, {4'd6, WR, SC, 8'h3B}, {4'd6, WR, FR, 8'h7F},
    {4'd6, WR, C, 8'h13}, {4'd6, IQ, C, 8'h00},  {4'd6, TK, C, 8'd1},  {4'd6, IQ, C, 8'h01},
    {4'd6, CL, C, 8'h00},                                                                     // R6 minutes
    {4'd6, WR, C, 8'h01}, {4'd6, WR, MN, 8'h3B}, {4'd6, WR, SC, 8'h3B}, {4'd6, WR, FR, 8'h7F},
    {4'd6, WR, C, 8'h1B}, {4'd6, TK, C, 8'd1},   {4'd6, IQ, C, 8'h01},                        // R6 hours
    {4'd7, RD, C, 8'h9B}, {4'd12, CL, C, 8'h00}, {4'd5, RD, C, 8'h1B}                         // R7 R12 R5
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq_clr = 1'b0;
  logic       irq;
  int         errs = 0;
  int         checks = 0;
  bit         finished = 1'b0;

  always #2 clk = ~clk;

  elapsed_interval_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_clr(irq_clr), .irq(irq)
  );

  task automatic check(input int req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL R%0d: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_read(input int req, input logic [2:0] a, input logic [7:0] e);
    @(negedge clk); addr = a; #1;
    check(req, rdata, e);
  endtask

  task automatic do_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic do_clear();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int v = 0; v < NV; v++) begin
      int         req;
      logic [2:0] op, a;
      logic [7:0] d;
      req = int'(VEC[v][17:14]);
      op  = VEC[v][13:11];
      a   = VEC[v][10:8];
      d   = VEC[v][7:0];
      case (op)
        WR: do_write(a, d);
        RD: do_read(req, a, d);
        TK: do_ticks(int'(d));
        IQ: begin @(negedge clk); check(req, {7'd0, irq}, d); end
        default: do_clear();
      endcase
    end

    // R12: a firing in the same cycle as a clear keeps the flag
    do_write(C, 8'h01);
    do_write(IV, 8'h01);
    do_write(C, 8'h03);
    @(negedge clk); tick = 1'b1; irq_clr = 1'b1;
    @(negedge clk); tick = 1'b0; irq_clr = 1'b0;
    check(12, {7'd0, irq}, 8'h01);
    // R12: a clear with no firing lowers it
    do_clear();
    check(12, {7'd0, irq}, 8'h00);

    // R1: reset in the middle of a run returns everything to zero
    do_write(FR, 8'h40);
    do_ticks(1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    do_read(1, FR, 8'h00);
    do_read(1, C, 8'h00);
    do_read(1, IC, 8'h00);
    check(1, {7'd0, irq}, 8'h00);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule